// File: doc/BRIEF.md
# DRAM Controller Event Counter Unit

This block watches the activity at the boundary of a DRAM controller and tallies it in four 32-bit counters. Events reach it in two forms. One is a vector of single-cycle pulses from the controller. The other is the address handshakes of the read and write request channels, each carrying a transaction ID. Each counter has its own event-code register. One shared ID/mask pair decides which IDs the two filtered event codes accept.

Counter 0 is the time base: it counts clock cycles whatever code it holds. When it runs past its top value, it wraps to zero, freezes all four counters and raises an interrupt. The interrupt stays high until software clears the unit. Counters 1 to 3 wrap without telling anyone.

Software uses a word-wide register port. Writes take effect at the clock edge. Reads are combinational from the address. The port can enable the unit, clear it, choose event codes, set the filter and preload or read any counter.

Top module: `mc_perf_monitor`

## Requirements
- R1: After reset all counters read 0, the unit is disabled (control bit 0 reads 0), the lock flag (control bit 2) is 0 and `irq` is low.
- R2: While enabled and not locked, counter 0 increases by exactly one per clock cycle. This holds whatever event code is programmed for it.
- R3: For counters 1 to 3, an event code c below the pulse-vector width adds one in every enabled, unlocked cycle in which `evt_pulse[c]` is high. A code that is at or above the width, and is neither 0x41 nor 0x42, counts nothing.
- R4: Code 0x41 adds one per read address handshake (`ar_valid` and `ar_ready` both high) whose ID passes the filter. Code 0x42 does the same for write address handshakes. A valid without ready counts nothing.
- R5: An ID passes when (ID AND mask) equals (filter ID AND mask). A mask bit of 1 makes that bit take part in the comparison, and a 0 ignores it. The filter register holds the filter ID in bits [ID_W-1:0] and the mask in bits [16+ID_W-1:16]. One pair is shared by all counters.
- R6: When counter 0 steps past all ones, it becomes 0 and the lock flag and `irq` rise on that edge. While locked, no counter changes except through a register write.
- R7: Counters 1 to 3 wrap from all ones to zero and keep counting, and `irq` is not raised.
- R8: Writing control with bit 1 set zeroes all counters and clears the lock and `irq` on that edge. Nothing else lowers `irq`, including rewriting the enable bit.
- R9: While the unit is disabled (control bit 0 = 0), no counter moves.
- R10: Register map: 0 = control, 1..4 = event code of counters 0..3, 5 = filter, 8..11 = counters 0..3. A write to a counter address loads that value and takes precedence over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | NUM_EVT | Single-cycle event pulses from the controller |
| ar_valid | input | 1 | Read address channel valid |
| ar_ready | input | 1 | Read address channel ready |
| ar_id | input | ID_W | Read transaction ID |
| aw_valid | input | 1 | Write address channel valid |
| aw_ready | input | 1 | Write address channel ready |
| aw_id | input | ID_W | Write transaction ID |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data for `reg_addr` |
| irq | output | 1 | Time-base expiry interrupt |

## Verification
The hardest state to reach is the expiry of counter 0. Counting there from zero would take over four billion cycles. The stimulus preloads counter 0 a few counts below all ones while the unit is enabled and an event pulse is held high on counter 3. It then watches the exact edge where the lock and `irq` appear, confirms that counter 3 stops at the same moment, and finally clears the unit. Filter behaviour is exercised from a vector table that mixes exact, partial and empty masks with handshakes that lack ready.

// File: rtl/mcpm_pkg.sv
package mcpm_pkg;
    localparam int ADDR_W = 4;
    localparam int FILT_MASK_LSB = 16;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEL0 = 4'd1;
    localparam logic [ADDR_W-1:0] A_FILT = 4'd5;
    localparam logic [ADDR_W-1:0] A_CNT0 = 4'd8;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_LOCK_BIT = 2;

    localparam logic [7:0] CODE_RD_MATCH = 8'h41;
    localparam logic [7:0] CODE_WR_MATCH = 8'h42;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_PULSE,
        SRC_RD,
        SRC_WR
    } src_e;
endpackage

// File: rtl/mcpm_id_filter.sv
module mcpm_id_filter #(
    parameter int ID_W = 12
) (
    input  logic [ID_W-1:0] flt_id,
    input  logic [ID_W-1:0] flt_mask,
    input  logic            ar_valid,
    input  logic            ar_ready,
    input  logic [ID_W-1:0] ar_id,
    input  logic            aw_valid,
    input  logic            aw_ready,
    input  logic [ID_W-1:0] aw_id,
    output logic            rd_hit,
    output logic            wr_hit
);
    logic [ID_W-1:0] ref_bits;
    logic            rd_match;
    logic            wr_match;

    always_comb begin
        ref_bits = flt_id & flt_mask;
        rd_match = ((ar_id & flt_mask) == ref_bits);
        wr_match = ((aw_id & flt_mask) == ref_bits);
        rd_hit   = ar_valid & ar_ready & rd_match;
        wr_hit   = aw_valid & aw_ready & wr_match;
    end
endmodule

// File: rtl/mcpm_event_select.sv
module mcpm_event_select
    import mcpm_pkg::*;
#(
    parameter int NUM_EVT = 64,
    parameter int CODE_W  = 8
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               rd_hit,
    input  logic               wr_hit,
    output logic               hit
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    src_e            src;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx = code[IDX_W-1:0];
        if (code == CODE_W'(CODE_RD_MATCH)) begin
            src = SRC_RD;
        end else if (code == CODE_W'(CODE_WR_MATCH)) begin
            src = SRC_WR;
        end else if (32'(code) < NUM_EVT) begin
            src = SRC_PULSE;
        end else begin
            src = SRC_NONE;
        end

        unique case (src)
            SRC_PULSE: hit = evt_pulse[idx];
            SRC_RD:    hit = rd_hit;
            SRC_WR:    hit = wr_hit;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/mcpm_count_slot.sv
module mcpm_count_slot #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             bump,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] nxt
);
    always_comb begin
        if (clr) begin
            nxt = '0;
        end else if (ld) begin
            nxt = ld_val;
        end else if (bump) begin
            nxt = cur + CNT_W'(1);
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/mc_perf_monitor.sv
module mc_perf_monitor
    import mcpm_pkg::*;
#(
    parameter int NUM_EVT = 64,
    parameter int ID_W    = 12,
    parameter int CNT_W   = 32,
    parameter int CODE_W  = 8,
    parameter int NUM_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               ar_valid,
    input  logic               ar_ready,
    input  logic [ID_W-1:0]    ar_id,
    input  logic               aw_valid,
    input  logic               aw_ready,
    input  logic [ID_W-1:0]    aw_id,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               irq
);
    localparam int MASK_LSB = FILT_MASK_LSB;

    typedef struct packed {
        logic                           en;
        logic                           locked;
        logic [NUM_CNT-1:0][CODE_W-1:0] code;
        logic [ID_W-1:0]                fid;
        logic [ID_W-1:0]                fmask;
        logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
    } state_t;

    state_t state_d, state_q;

    logic               rd_hit, wr_hit;
    logic [NUM_CNT-1:0] inc;
    logic [NUM_CNT-1:0] bump;
    logic [NUM_CNT-1:0] ld;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_nxt;
    logic               clr;
    logic               active;
    logic               expire;

    logic                     en_view;
    logic                     lock_view;
    logic [NUM_CNT*CNT_W-1:0] cnt_view;

    mcpm_id_filter #(.ID_W(ID_W)) u_filter (
        .flt_id   (state_q.fid),
        .flt_mask (state_q.fmask),
        .ar_valid (ar_valid),
        .ar_ready (ar_ready),
        .ar_id    (ar_id),
        .aw_valid (aw_valid),
        .aw_ready (aw_ready),
        .aw_id    (aw_id),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit)
    );

    always_comb begin
        clr    = reg_we && (reg_addr == A_CTRL) && reg_wdata[CTRL_CLR_BIT];
        active = state_q.en & ~state_q.locked;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
        if (i == 0) begin : g_time
            assign inc[i] = 1'b1;
        end else begin : g_evt
            mcpm_event_select #(
                .NUM_EVT (NUM_EVT),
                .CODE_W  (CODE_W)
            ) u_sel (
                .code      (state_q.code[i]),
                .evt_pulse (evt_pulse),
                .rd_hit    (rd_hit),
                .wr_hit    (wr_hit),
                .hit       (inc[i])
            );
        end

        assign ld[i]   = reg_we && (reg_addr == ADDR_W'(int'(A_CNT0) + i));
        assign bump[i] = active & inc[i];

        mcpm_count_slot #(.CNT_W(CNT_W)) u_cnt (
            .cur    (state_q.cnt[i]),
            .bump   (bump[i]),
            .clr    (clr),
            .ld     (ld[i]),
            .ld_val (reg_wdata),
            .nxt    (cnt_nxt[i])
        );
    end

    assign expire = bump[0] & (&state_q.cnt[0]) & ~clr & ~ld[0];

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_nxt;

        if (reg_we && reg_addr == A_CTRL) begin
            state_d.en = reg_wdata[CTRL_EN_BIT];
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_we && reg_addr == ADDR_W'(int'(A_SEL0) + i)) begin
                state_d.code[i] = reg_wdata[CODE_W-1:0];
            end
        end
        if (reg_we && reg_addr == A_FILT) begin
            state_d.fid   = reg_wdata[ID_W-1:0];
            state_d.fmask = reg_wdata[MASK_LSB +: ID_W];
        end

        if (clr) begin
            state_d.locked = 1'b0;
        end else if (expire) begin
            state_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[CTRL_EN_BIT]   = state_q.en;
            reg_rdata[CTRL_LOCK_BIT] = state_q.locked;
        end else if (reg_addr == A_FILT) begin
            reg_rdata[ID_W-1:0]         = state_q.fid;
            reg_rdata[MASK_LSB +: ID_W] = state_q.fmask;
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(int'(A_SEL0) + i)) begin
                reg_rdata[CODE_W-1:0] = state_q.code[i];
            end
            if (reg_addr == ADDR_W'(int'(A_CNT0) + i)) begin
                reg_rdata = state_q.cnt[i];
            end
        end
    end

    assign irq       = state_q.locked;
    assign en_view   = state_q.en;
    assign lock_view = state_q.locked;
    assign cnt_view  = state_q.cnt;
endmodule

// File: rtl/mcpm_checker.sv
module mcpm_checker #(
    parameter int CNT_W   = 32,
    parameter int NUM_CNT = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic [3:0]               reg_addr,
    input logic                     clr_bit,
    input logic                     irq,
    input logic                     en,
    input logic                     locked,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
    logic [CNT_W-1:0] c0;
    logic             clr_req;

    assign c0      = cnt_flat[CNT_W-1:0];
    assign clr_req = reg_we && (reg_addr == 4'd0) && clr_bit;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !en && cnt_flat == '0));

    assert_time_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !locked && !reg_we) |=> (c0 == CNT_W'($past(c0) + CNT_W'(1))));

    assert_lock_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(c0) == {CNT_W{1'b1}} && c0 == '0));

    assert_lock_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !reg_we) |=> $stable(cnt_flat));

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_req) |=> irq);

    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reg_we) |=> $stable(cnt_flat));
endmodule

bind mc_perf_monitor mcpm_checker #(
    .CNT_W   (CNT_W),
    .NUM_CNT (NUM_CNT)
) u_mcpm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .clr_bit  (reg_wdata[1]),
    .irq      (irq),
    .en       (en_view),
    .locked   (lock_view),
    .cnt_flat (cnt_view)
);

// File: tb/test_mc_perf_monitor.sv
module test_mc_perf_monitor;
    localparam int NUM_EVT = 64;
    localparam int ID_W    = 12;
    localparam int CNT_W   = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt_pulse = '0;
    logic               ar_valid = 1'b0, ar_ready = 1'b0;
    logic [ID_W-1:0]    ar_id = '0;
    logic               aw_valid = 1'b0, aw_ready = 1'b0;
    logic [ID_W-1:0]    aw_id = '0;
    logic               reg_we = 1'b0;
    logic [3:0]         reg_addr = '0;
    logic [CNT_W-1:0]   reg_wdata = '0;
    logic [CNT_W-1:0]   reg_rdata;
    logic               irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    mc_perf_monitor i_mc_perf_monitor (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [11:0] fid;
        logic [11:0] fmask;
        logic [11:0] axid;
        logic        is_wr;
        logic        rdy;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{12'h012, 12'hFFF, 12'h012, 1'b0, 1'b1, 1'b1},
        '{12'h012, 12'hFFF, 12'h013, 1'b0, 1'b1, 1'b0},
        '{12'h010, 12'hFF0, 12'h01F, 1'b0, 1'b1, 1'b1},
        '{12'h0A0, 12'h000, 12'h5C3, 1'b0, 1'b1, 1'b1},
        '{12'h012, 12'hFFF, 12'h012, 1'b0, 1'b0, 1'b0},
        '{12'h300, 12'hF00, 12'h3AB, 1'b1, 1'b1, 1'b1},
        '{12'h300, 12'hF00, 12'h4AB, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] a, b, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        rd(4'd0, a); check("R1 control", a, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rd(4'(8 + i), a); check("R1 counter", a, 32'd0);
        end

        // program codes: counter0 gets a filtered code that must be ignored (R2)
        wr(4'd1, 32'h41);
        wr(4'd2, 32'h41);
        wr(4'd3, 32'h42);
        wr(4'd4, 32'd5);

        // R9: disabled, events present
        evt_pulse[5] = 1'b1;
        repeat (3) @(negedge clk);
        evt_pulse[5] = 1'b0;
        rd(4'd11, a); check("R9 counter3 idle", a, 32'd0);
        rd(4'd8, a);  check("R9 counter0 idle", a, 32'd0);

        wr(4'd0, 32'd1);

        // R2: one per cycle
        for (int k = 0; k < 2; k++) begin
            rd(4'd8, a);
            @(negedge clk);
            rd(4'd8, b);
            check("R2 time step", b - a, 32'd1);
        end

        // R3: direct pulse index
        rd(4'd11, a);
        evt_pulse[5] = 1'b1;
        repeat (4) @(negedge clk);
        evt_pulse[5] = 1'b0;
        rd(4'd11, b);
        check("R3 pulse count", b - a, 32'd4);

        evt_pulse[6] = 1'b1;
        @(negedge clk);
        evt_pulse[6] = 1'b0;
        rd(4'd11, c);
        check("R3 other index ignored", c, b);

        // R3: out-of-range code 0x50 counts nothing
        wr(4'd4, 32'h50);
        rd(4'd11, a);
        evt_pulse = '1;
        repeat (3) @(negedge clk);
        evt_pulse = '0;
        rd(4'd11, b);
        check("R3 out-of-range code", b, a);
        wr(4'd4, 32'd5);

        // R4/R5: filter vector table
        foreach (VECS[n]) begin
            wr(4'd5, {4'b0, VECS[n].fmask, 4'b0, VECS[n].fid});
            rd(4'd9, a);
            rd(4'd10, b);
            if (VECS[n].is_wr) begin
                aw_valid = 1'b1; aw_ready = VECS[n].rdy; aw_id = VECS[n].axid;
            end else begin
                ar_valid = 1'b1; ar_ready = VECS[n].rdy; ar_id = VECS[n].axid;
            end
            @(negedge clk);
            ar_valid = 1'b0; ar_ready = 1'b0; aw_valid = 1'b0; aw_ready = 1'b0;
            rd(4'd9, c);
            check("R4 R5 read filter", c - a,
                  (!VECS[n].is_wr && VECS[n].exp) ? 32'd1 : 32'd0);
            rd(4'd10, c);
            check("R4 R5 write filter", c - b,
                  (VECS[n].is_wr && VECS[n].exp) ? 32'd1 : 32'd0);
        end

        // R10: preload, R7: silent wrap
        wr(4'd11, 32'hFFFF_FFFE);
        rd(4'd11, a); check("R10 preload", a, 32'hFFFF_FFFE);
        evt_pulse[5] = 1'b1;
        repeat (3) @(negedge clk);
        rd(4'd11, a); check("R7 wrap", a, 32'd1);
        check("R7 no irq", {31'b0, irq}, 32'd0);
        wr(4'd11, 32'd100);
        rd(4'd11, a); check("R10 write beats increment", a, 32'd100);

        // R6: time base expiry, event still high on counter 3
        wr(4'd8, 32'hFFFF_FFFD);
        repeat (2) @(negedge clk);
        rd(4'd8, a); check("R6 before expiry", a, 32'hFFFF_FFFF);
        check("R6 irq not early", {31'b0, irq}, 32'd0);
        @(negedge clk);
        rd(4'd8, a); check("R6 counter0 wraps", a, 32'd0);
        check("R6 irq raised", {31'b0, irq}, 32'd1);
        rd(4'd0, a); check("R6 lock flag", a & 32'h4, 32'h4);
        rd(4'd11, b);
        repeat (4) @(negedge clk);
        rd(4'd11, c); check("R6 counter3 frozen", c, b);
        rd(4'd8, c);  check("R6 counter0 frozen", c, 32'd0);

        // R8: irq holds through an enable rewrite
        wr(4'd0, 32'd1);
        check("R8 irq held", {31'b0, irq}, 32'd1);
        @(negedge clk);
        check("R8 irq still held", {31'b0, irq}, 32'd1);

        // R8: clear
        wr(4'd0, 32'd3);
        check("R8 irq cleared", {31'b0, irq}, 32'd0);
        rd(4'd8, a);  check("R8 counter0 zeroed", a, 32'd0);
        rd(4'd11, a); check("R8 counter3 zeroed", a, 32'd0);
        rd(4'd0, a);  check("R8 lock cleared", a & 32'h4, 32'd0);
        @(negedge clk);
        rd(4'd8, a);  check("R8 counting resumes", a, 32'd1);
        evt_pulse = '0;

        finish_run();
    end
endmodule